// File: doc/BRIEF.md
# Variable-Size Register Window Stack

This block is the register file behind procedure calls. It holds a circular stack of 128 registers, addressed relative to a stack pointer, and 64 global registers, addressed absolutely. A call request gives the exact number of registers the callee needs. The block then opens a frame of that size on top of the stack, so a routine with one local value and a return address takes only two registers. A return request gives the size of the frame being released and the size of the caller's frame, and the stack pointer moves back to the caller.

The block counts how many stack registers are resident on chip. If a new frame would push that count past 128, the oldest resident registers are first written out, one word per accepted beat, to a memory-resident stack over a valid/ready port. On a return, if the caller's frame is no longer fully on chip, the missing words are read back from memory before the caller goes on. While either transfer runs, `stall` stays high and the block ignores register writes and new requests. No register is reserved for condition codes: any register, local or global, can hold a comparison result.

Top module: `rws_stack`

## Requirements
- R1: After a synchronous reset, `stall` and `memValid` are low and every local and global register reads as zero.
- R2: An address with bit 7 clear is a local offset. It selects physical stack register (sp + offset) mod 128. After a call, sp is the old top of stack, so offset 0 is the first register of the new frame. A read returns the last value written through the same offset in the same frame.
- R3: An address with bit 7 set selects global register addr[5:0]. Global registers are never changed by calls, returns, spills or fills.
- R4: A call whose size fits (resident count plus size at most 128) causes no memory traffic and never raises `stall`.
- R5: A call that does not fit first spills exactly (count + size − 128) of the oldest resident words, with `memWrite` high. Addresses go up by one per beat, starting at the current memory depth, so memory address k holds logical stack word k.
- R6: A return with release size R and caller size C leaves max(count − R, 0) words resident. It then fills min(C − that, memory depth) words, if that is positive, with `memWrite` low and addresses going down by one per beat. Afterwards the whole caller frame reads back its earlier values.
- R7: `stall` goes high in the cycle after a request that needs a transfer. It stays high until the last beat is accepted, and it never falls without an accepted beat.
- R8: While `stall` is high, register writes and call and return requests have no effect.
- R9: A call, or a return, that gives a size above 128 is ignored. A call takes priority over a return in the same cycle.
- R10: While `memValid` is high and `memReady` is low, the memory address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| callReq | input | 1 | Open a new frame |
| callSize | input | 8 | Registers requested by the callee |
| retReq | input | 1 | Release the current frame |
| retSize | input | 8 | Size of the frame being released |
| callerSize | input | 8 | Size of the caller's frame to make resident |
| rdAddrA | input | 8 | Read address A (bit 7: global select) |
| rdDataA | output | 32 | Read data A |
| rdAddrB | input | 8 | Read address B |
| rdDataB | output | 32 | Read data B |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 8 | Register write address |
| wrData | input | 32 | Register write data |
| stall | output | 1 | Spill or fill in progress |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = spill write, 0 = fill read |
| memAddr | output | 16 | Memory stack word address |
| memWdata | output | 32 | Spill data |
| memRdata | input | 32 | Fill data, valid with memReady |
| memReady | input | 1 | Memory accepts the beat |

## Verification
The bench first drives directed sequences. A frame filling the stack exactly must produce no traffic. A one-word call on a full stack must spill one word. A 128-register call must spill everything, and the two returns after it must refill first a tiny frame and then a nearly full one. Together these separate an off-by-one at the capacity limit from a wrong choice of the oldest word. Random sequences then mix small, large and zero-size frames with returns, under random memory back-pressure. This shows whether spill and fill order, the memory depth and the sp-relative addressing stay consistent across wrap-around. Oversize sizes, and writes or returns sent during a spill, separate requests that are really ignored from ones that leak into state.

// File: rtl/rws_pkg.sv
package rws_pkg;
  parameter int DEF_STACK_REGS  = 128;
  parameter int DEF_GLOBAL_REGS = 64;
  localparam int DEF_IDX_W      = $clog2(DEF_STACK_REGS);

  // strobes from control to datapath
  typedef struct packed {
    logic                 userWe;   // port write allowed this cycle
    logic                 fillWe;   // fill beat lands in the stack
    logic [DEF_IDX_W-1:0] xferIdx;  // physical register of current transfer
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SPILL, ST_FILL} state_t;
endpackage

// File: rtl/rws_datapath.sv
module rws_datapath #(
  parameter int STACK_REGS  = rws_pkg::DEF_STACK_REGS,
  parameter int GLOBAL_REGS = rws_pkg::DEF_GLOBAL_REGS,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = $clog2(STACK_REGS) + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  rws_pkg::strobe_t              strb,
  input  logic [$clog2(STACK_REGS)-1:0] sp,
  input  logic [ADDR_W-1:0]             rdAddrA,
  input  logic [ADDR_W-1:0]             rdAddrB,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W-1:0]             memRdata,
  output logic [DATA_W-1:0]             rdDataA,
  output logic [DATA_W-1:0]             rdDataB,
  output logic [DATA_W-1:0]             spillData
);
  localparam int IDX_W  = $clog2(STACK_REGS);
  localparam int GIDX_W = $clog2(GLOBAL_REGS);
  localparam int RD_PORTS = 2;

  logic [DATA_W-1:0] stackMem [STACK_REGS];
  logic [DATA_W-1:0] globMem  [GLOBAL_REGS];

  logic [ADDR_W-1:0] rdAddr [RD_PORTS];
  logic [DATA_W-1:0] rdData [RD_PORTS];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  // one read mux per port: global by absolute index, local relative to sp
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [IDX_W-1:0] localIdx;
    assign localIdx  = sp + rdAddr[p][IDX_W-1:0];
    assign rdData[p] = rdAddr[p][ADDR_W-1] ? globMem[rdAddr[p][GIDX_W-1:0]]
                                            : stackMem[localIdx];
  end

  logic [IDX_W-1:0] wrLocalIdx;
  assign wrLocalIdx = sp + wrAddr[IDX_W-1:0];
  assign spillData  = stackMem[strb.xferIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STACK_REGS; i++)  stackMem[i] <= '0;
      for (int i = 0; i < GLOBAL_REGS; i++) globMem[i]  <= '0;
    end else begin
      if (strb.fillWe) stackMem[strb.xferIdx] <= memRdata;
      if (strb.userWe) begin
        if (wrAddr[ADDR_W-1]) globMem[wrAddr[GIDX_W-1:0]] <= wrData;
        else                  stackMem[wrLocalIdx]        <= wrData;
      end
    end
  end
endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl #(
  parameter int STACK_REGS = rws_pkg::DEF_STACK_REGS,
  parameter int MEM_ADDR_W = 16,
  parameter int SIZE_W     = $clog2(STACK_REGS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          callReq,
  input  logic [SIZE_W-1:0]             callSize,
  input  logic                          retReq,
  input  logic [SIZE_W-1:0]             retSize,
  input  logic [SIZE_W-1:0]             callerSize,
  input  logic                          wrEn,
  input  logic                          memReady,
  output logic                          stall,
  output logic                          memValid,
  output logic                          memWrite,
  output logic [MEM_ADDR_W-1:0]         memAddr,
  output logic [$clog2(STACK_REGS)-1:0] sp,
  output rws_pkg::strobe_t              strb
);
  localparam int IDX_W = $clog2(STACK_REGS);
  localparam logic [SIZE_W:0] CAP = (SIZE_W+1)'(STACK_REGS);

  rws_pkg::state_t state;
  logic [IDX_W-1:0]      top;       // physical index of next free register
  logic [SIZE_W-1:0]     count;     // resident stack registers
  logic [SIZE_W-1:0]     remain;    // beats left in current transfer
  logic [SIZE_W-1:0]     pendSize;  // frame opened once spill is done
  logic [MEM_ADDR_W-1:0] depth;     // words held in memory

  logic                  callOk, retOk;
  logic [SIZE_W:0]       sum;
  logic [SIZE_W-1:0]     keep, need, nFill;
  logic [IDX_W-1:0]      newTop, oldestIdx;

  always_comb begin
    callOk = callReq && ({1'b0, callSize} <= CAP);
    retOk  = retReq && ({1'b0, retSize} <= CAP) && ({1'b0, callerSize} <= CAP);
    sum    = {1'b0, count} + {1'b0, callSize};
    keep   = (count > retSize) ? count - retSize : '0;
    newTop = top - retSize[IDX_W-1:0];
    need   = (callerSize > keep) ? callerSize - keep : '0;
    nFill  = (MEM_ADDR_W'(need) > depth) ? depth[SIZE_W-1:0] : need;
    oldestIdx = top - count[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= rws_pkg::ST_IDLE;
      top      <= '0;
      sp       <= '0;
      count    <= '0;
      remain   <= '0;
      pendSize <= '0;
      depth    <= '0;
    end else begin
      case (state)
        rws_pkg::ST_IDLE: begin
          if (callOk) begin
            sp <= top;
            if (sum > CAP) begin
              remain   <= SIZE_W'(sum - CAP);
              pendSize <= callSize;
              state    <= rws_pkg::ST_SPILL;
            end else begin
              top   <= top + callSize[IDX_W-1:0];
              count <= sum[SIZE_W-1:0];
            end
          end else if (retOk) begin
            top   <= newTop;
            count <= keep;
            sp    <= newTop - callerSize[IDX_W-1:0];
            if (nFill != '0) begin
              remain <= nFill;
              state  <= rws_pkg::ST_FILL;
            end
          end
        end
        rws_pkg::ST_SPILL: begin
          if (memReady) begin
            depth  <= depth + MEM_ADDR_W'(1);
            remain <= remain - SIZE_W'(1);
            if (remain == SIZE_W'(1)) begin
              count <= count - SIZE_W'(1) + pendSize;
              top   <= top + pendSize[IDX_W-1:0];
              state <= rws_pkg::ST_IDLE;
            end else begin
              count <= count - SIZE_W'(1);
            end
          end
        end
        rws_pkg::ST_FILL: begin
          if (memReady) begin
            depth  <= depth - MEM_ADDR_W'(1);
            count  <= count + SIZE_W'(1);
            remain <= remain - SIZE_W'(1);
            if (remain == SIZE_W'(1)) state <= rws_pkg::ST_IDLE;
          end
        end
        default: state <= rws_pkg::ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stall        = (state != rws_pkg::ST_IDLE);
    memValid     = stall;
    memWrite     = (state == rws_pkg::ST_SPILL);
    memAddr      = memWrite ? depth : depth - MEM_ADDR_W'(1);
    strb.userWe  = wrEn && (state == rws_pkg::ST_IDLE);
    strb.fillWe  = (state == rws_pkg::ST_FILL) && memReady;
    strb.xferIdx = memWrite ? oldestIdx : oldestIdx - IDX_W'(1);
  end
endmodule

// File: rtl/rws_stack.sv
module rws_stack #(
  parameter int STACK_REGS  = rws_pkg::DEF_STACK_REGS,
  parameter int GLOBAL_REGS = rws_pkg::DEF_GLOBAL_REGS,
  parameter int DATA_W      = 32,
  parameter int MEM_ADDR_W  = 16,
  localparam int SIZE_W     = $clog2(STACK_REGS + 1),
  localparam int ADDR_W     = $clog2(STACK_REGS) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  callReq,
  input  logic [SIZE_W-1:0]     callSize,
  input  logic                  retReq,
  input  logic [SIZE_W-1:0]     retSize,
  input  logic [SIZE_W-1:0]     callerSize,
  input  logic [ADDR_W-1:0]     rdAddrA,
  output logic [DATA_W-1:0]     rdDataA,
  input  logic [ADDR_W-1:0]     rdAddrB,
  output logic [DATA_W-1:0]     rdDataB,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic                  stall,
  output logic                  memValid,
  output logic                  memWrite,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]     memWdata,
  input  logic [DATA_W-1:0]     memRdata,
  input  logic                  memReady
);
  rws_pkg::strobe_t              strb;
  logic [$clog2(STACK_REGS)-1:0] sp;

  rws_ctrl #(.STACK_REGS(STACK_REGS), .MEM_ADDR_W(MEM_ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .callReq(callReq), .callSize(callSize),
    .retReq(retReq), .retSize(retSize), .callerSize(callerSize),
    .wrEn(wrEn), .memReady(memReady), .stall(stall), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .sp(sp), .strb(strb)
  );

  rws_datapath #(.STACK_REGS(STACK_REGS), .GLOBAL_REGS(GLOBAL_REGS),
                 .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .sp(sp),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .memRdata(memRdata), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .spillData(memWdata)
  );
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
  parameter int STACK_REGS = 128,
  parameter int DATA_W     = 32,
  parameter int MEM_ADDR_W = 16,
  parameter int SIZE_W     = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  callReq,
  input logic [SIZE_W-1:0]     callSize,
  input logic                  retReq,
  input logic                  stall,
  input logic                  memValid,
  input logic                  memWrite,
  input logic [MEM_ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0]     memWdata,
  input logic                  memReady
);
  localparam logic [SIZE_W:0] CAP = (SIZE_W+1)'(STACK_REGS);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));

  p_spill_up_r5: assert property (@(posedge clk) disable iff (rst)
    memValid && memReady && memWrite |=> !memWrite || (memAddr == $past(memAddr) + MEM_ADDR_W'(1)));

  p_fill_down_r6: assert property (@(posedge clk) disable iff (rst)
    memValid && memReady && !memWrite |=> !memValid || memWrite || (memAddr == $past(memAddr) - MEM_ADDR_W'(1)));

  p_oversize_r9: assert property (@(posedge clk) disable iff (rst)
    !stall && callReq && !retReq && ({1'b0, callSize} > CAP) |=> !stall);

  p_stall_ends_on_beat_r7: assert property (@(posedge clk) disable iff (rst)
    stall && !(memValid && memReady) |=> stall);
endmodule

bind rws_stack rws_checker #(.STACK_REGS(STACK_REGS), .DATA_W(DATA_W),
                             .MEM_ADDR_W(MEM_ADDR_W), .SIZE_W(SIZE_W)) uChk (
  .clk(clk), .rst(rst), .callReq(callReq), .callSize(callSize), .retReq(retReq),
  .stall(stall), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady)
);

// File: tb/rws_stack_test.sv
module rws_stack_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        callReq = 1'b0, retReq = 1'b0, wrEn = 1'b0, memReady = 1'b0;
  logic [7:0]  callSize = '0, retSize = '0, callerSize = '0;
  logic [7:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] wrData = '0, rdDataA, rdDataB, memWdata, memRdata;
  logic        stall, memValid, memWrite;
  logic [15:0] memAddr;

  int checks = 0, failures = 0, cycles = 0;
  int expMem = 0, spillBeats = 0, fillBeats = 0;
  int refCount = 0, topL = 0, depthF = 0;
  int frames [0:511];
  int bases  [0:511];
  logic [31:0] refStack [0:8191];
  logic [31:0] refGlob  [0:63];
  logic [31:0] memArr   [0:8191];

  rws_stack uut (
    .clk(clk), .rst(rst), .callReq(callReq), .callSize(callSize),
    .retReq(retReq), .retSize(retSize), .callerSize(callerSize),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .stall(stall),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  always #10 clk = ~clk;

  assign memRdata = memArr[memAddr[12:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with random back-pressure; beats judged before the coming edge
  always @(negedge clk) begin
    memReady = ($urandom % 4) != 0;
    if (!rst && memValid && memReady) begin
      if (memWrite) begin
        chk(memAddr == 16'(expMem), "R5 spill address", 32'(memAddr), 32'(expMem));
        chk(memWdata === refStack[expMem], "R5 spill data", memWdata, refStack[expMem]);
        memArr[expMem] = memWdata;
        expMem++;
        spillBeats++;
      end else begin
        chk(memAddr == 16'(expMem - 1), "R6 fill address", 32'(memAddr), 32'(expMem - 1));
        expMem--;
        fillBeats++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic checkFrame(input string tag);
    int n = frames[depthF-1];
    int b = bases[depthF-1];
    for (int o = 0; o < n; o++) begin
      rdAddrA = 8'(o);
      rdAddrB = 8'(n - 1 - o);
      #1;
      chk(rdDataA === refStack[b+o], tag, rdDataA, refStack[b+o]);
      chk(rdDataB === refStack[b+n-1-o], tag, rdDataB, refStack[b+n-1-o]);
    end
    @(negedge clk);
  endtask

  task automatic checkGlobals();
    for (int g = 0; g < 64; g++) begin
      rdAddrB = 8'h80 | 8'(g);
      #1;
      chk(rdDataB === refGlob[g], "R3 global unchanged", rdDataB, refGlob[g]);
    end
    @(negedge clk);
  endtask

  task automatic doCall(input int n, input bit poke);
    int expSpill = (refCount + n > 128) ? refCount + n - 128 : 0;
    bit poked = 0;
    spillBeats = 0; fillBeats = 0;
    callReq = 1'b1; callSize = 8'(n);
    @(negedge clk);
    callReq = 1'b0;
    if (expSpill > 0) chk(stall === 1'b1, "R7 stall during spill", 32'(stall), 1);
    else              chk(stall === 1'b0, "R4 no stall when frame fits", 32'(stall), 0);
    if (poke && stall) begin
      // R8: write and return while stalled must be dropped
      poked = 1;
      wrEn = 1'b1; wrAddr = 8'h85; wrData = ~refGlob[5];
      retReq = 1'b1; retSize = 8'd1; callerSize = 8'd1;
      @(negedge clk);
      wrEn = 1'b0; retReq = 1'b0;
    end
    while (stall) @(negedge clk);
    chk(spillBeats == expSpill, expSpill > 0 ? "R5 spill count" : "R4 no traffic",
        32'(spillBeats), 32'(expSpill));
    chk(fillBeats == 0, "R5 no fill on call", 32'(fillBeats), 0);
    if (poked) begin
      rdAddrA = 8'h85; #1;
      chk(rdDataA === refGlob[5], "R8 write during stall ignored", rdDataA, refGlob[5]);
      @(negedge clk);
    end
    refCount = refCount + n - expSpill;
    frames[depthF] = n; bases[depthF] = topL; depthF++; topL += n;
    for (int o = 0; o < n; o++) begin
      wrEn = 1'b1; wrAddr = 8'(o); wrData = $urandom;
      refStack[bases[depthF-1] + o] = wrData;
      @(negedge clk);
    end
    wrEn = 1'b0;
    checkFrame(poked ? "R8 request during stall ignored" : "R2 frame readback");
  endtask

  task automatic doReturn();
    int r = frames[depthF-1];
    int c = frames[depthF-2];
    int keep = refCount - r;
    int need = (c > keep) ? c - keep : 0;
    int nFill = (need > expMem) ? expMem : need;
    spillBeats = 0; fillBeats = 0;
    retReq = 1'b1; retSize = 8'(r); callerSize = 8'(c);
    @(negedge clk);
    retReq = 1'b0;
    chk(stall === (nFill > 0), "R7 stall on fill", 32'(stall), 32'(nFill > 0));
    while (stall) @(negedge clk);
    chk(fillBeats == nFill, "R6 fill count", 32'(fillBeats), 32'(nFill));
    chk(spillBeats == 0, "R6 no spill on return", 32'(spillBeats), 0);
    refCount = keep + nFill;
    depthF--; topL -= r;
    checkFrame("R6 caller frame restored");
  endtask

  task automatic doOversize(input int n);
    spillBeats = 0;
    callReq = 1'b1; callSize = 8'(n);
    @(negedge clk);
    callReq = 1'b0;
    chk(stall === 1'b0, "R9 oversize call no stall", 32'(stall), 0);
    @(negedge clk);
    chk(spillBeats == 0, "R9 oversize call no traffic", 32'(spillBeats), 0);
    checkFrame("R9 frame unchanged after oversize call");
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (4) @(negedge clk);
    chk(stall === 1'b0, "R1 stall low in reset", 32'(stall), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(stall === 1'b0, "R1 stall low after reset", 32'(stall), 0);
    chk(memValid === 1'b0, "R1 no memory request after reset", 32'(memValid), 0);
    for (int a = 0; a < 128; a += 37) begin
      rdAddrA = 8'(a); rdAddrB = 8'h80 | 8'(a % 64); #1;
      chk(rdDataA === 32'd0, "R1 local zero", rdDataA, 0);
      chk(rdDataB === 32'd0, "R1 global zero", rdDataB, 0);
    end
    @(negedge clk);

    for (int g = 0; g < 64; g++) begin
      wrEn = 1'b1; wrAddr = 8'h80 | 8'(g); wrData = $urandom;
      refGlob[g] = wrData;
      @(negedge clk);
    end
    wrEn = 1'b0;
    checkGlobals();

    // directed corners around the capacity limit
    doCall(2, 0);
    doCall(126, 0);     // exactly full, no spill (R4)
    doCall(1, 1);       // one word spilled (R5)
    doCall(128, 1);     // whole stack replaced (R5)
    doOversize(200);    // R9
    doReturn();         // small caller refilled (R6)
    doReturn();         // large caller refilled (R6)
    doCall(0, 0);       // empty frame
    doReturn();
    checkGlobals();

    for (int op = 0; op < 250; op++) begin
      int r = $urandom % 16;
      if (r == 0) doOversize(129 + ($urandom % 127));
      else if (depthF < 2 || (r < 9 && depthF < 400 && topL < 7800)) begin
        int s = $urandom % 16;
        int n = (s == 0) ? 0 : (s < 3) ? 100 + ($urandom % 29) : 1 + ($urandom % 40);
        doCall(n, ($urandom % 3) == 0);
      end else doReturn();
      if (op % 25 == 0) checkGlobals();
    end
    while (depthF > 1) doReturn();
    checkGlobals();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule